// File: doc/BRIEF.md
# Interrupt Controller Command Interface

This block is the software-facing programming front end of an eight-line interrupt controller. Two byte-wide ports are exposed: a command port and a data port. Each port has its own write strobe, read strobe, write data and read data. A byte on the command port with bit 4 set starts initialisation and is kept as init word 1. The following data-port writes fill init words 2, 3 and 4, and two bits of init word 1 decide whether words 3 and 4 are expected at all. After that the block is ready: data-port writes load the interrupt mask, and command-port bytes are either end-of-interrupt commands or readback-select commands.

The block does not hold the request and in-service registers. It reads them from the neighbouring request logic and answers with single-cycle clear pulses for in-service bits. Command-port reads return the request vector, the in-service vector or zero, as chosen by the last readback-select byte. A malformed or out-of-sequence write raises a one-cycle error pulse and changes no state.

All outputs are registered. Stored words, the clear pulses, the error pulse and the read data all change on the clock edge that samples the strobe.

Top module: `picc_cmd_if`

## Requirements
- R1: After reset, ready is 0, irq_mask is 0xFF, init words 1 to 4, last_eoi_cmd and read_sel_cmd are 0x00, and err and svc_clr are 0.
- R2: A command-port write with bit 4 set is stored as init word 1 in any state, including ready. It drops ready, and the next data-port write becomes init word 2.
- R3: Data-port writes during initialisation fill word 2 first. Word 3 follows only when word 1 bit 1 is 0. Word 4 follows only when word 1 bit 0 is 1. Then ready rises. A skipped word keeps its old value.
- R4: While ready, a data-port write loads irq_mask. A data-port read returns irq_mask on dat_rdata on the following cycle.
- R5: While ready, a command byte with bits 4:3 = 01 is stored in read_sel_cmd. A command-port read then returns req_in when read_sel_cmd[1:0] = 10, svc_in when it is 11, and 0x00 otherwise, on cmd_rdata on the following cycle.
- R6: While ready, a command byte with bits 7:5 = 001 and bits 4:3 = 00 is stored in last_eoi_cmd. It pulses svc_clr for one cycle with only the lowest set bit of svc_in, and with 0x00 when svc_in is empty.
- R7: While ready, a command byte with bits 7:5 = 011 and bits 4:3 = 00 is stored in last_eoi_cmd. It pulses the svc_clr bit selected by bits 2:0 of that byte.
- R8: While ready, a command byte with bits 4:3 = 00 and bits 7:5 other than 001 or 011 pulses err. It stores nothing and leaves svc_clr at 0.
- R9: A command byte with bit 4 clear, written before ready, pulses err and stores nothing.
- R10: A data-port write before any init word 1 pulses err and leaves irq_mask and ready unchanged.
- R11: err is high only for the one cycle after an offending write, and is 0 after any accepted write.
- R12: When cmd_wr and dat_wr are high in the same cycle, only the command write takes effect and the data write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command-port write strobe |
| cmd_rd | input | 1 | Command-port read strobe |
| cmd_wdata | input | 8 | Command-port write byte |
| cmd_rdata | output | 8 | Command-port read byte (registered) |
| dat_wr | input | 1 | Data-port write strobe |
| dat_rd | input | 1 | Data-port read strobe |
| dat_wdata | input | 8 | Data-port write byte |
| dat_rdata | output | 8 | Data-port read byte (registered) |
| req_in | input | 8 | Pending-request vector from the request logic |
| svc_in | input | 8 | In-service vector from the request logic |
| svc_clr | output | 8 | One-cycle in-service clear pulses |
| err | output | 1 | One-cycle error pulse |
| ready | output | 1 | Initialisation complete |
| init_word1 | output | 8 | Stored init word 1 |
| init_word2 | output | 8 | Stored init word 2 (vector base) |
| init_word3 | output | 8 | Stored init word 3 (cascade) |
| init_word4 | output | 8 | Stored init word 4 (mode) |
| irq_mask | output | 8 | Interrupt mask |
| last_eoi_cmd | output | 8 | Last accepted end-of-interrupt command |
| read_sel_cmd | output | 8 | Last accepted readback-select command |

## Verification
The assertions check the following on every cycle. svc_clr never has more than one bit set. A lowest-bit clear never targets a bit that was not in service. A restart byte always puts the sequencer back to expecting word 2. The mask changes only after a data write in the ready state. Every error pulse traces back to a write, and a rejected command leaves the stored end-of-interrupt byte and svc_clr untouched. The bench scenarios are needed to show the things no single-cycle property covers. These are the exact skip pattern of words 3 and 4 for each combination of word 1 bits, the selected readback source, the lowest-set-bit choice on real in-service patterns, and the dropping of a data write that collides with a command write.

// File: rtl/picc_pkg.sv
package picc_pkg;

    localparam int LVL_W  = 3;
    localparam int BYTE_W = 1 << LVL_W;

    // bit positions in command and init bytes
    localparam int RESTART_BIT = 4;
    localparam int KIND_BIT    = 3;
    localparam int SOLO_BIT    = 1;
    localparam int WANT4_BIT   = 0;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [LVL_W-1:0]  lvl_t;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_WANT2,
        SEQ_WANT3,
        SEQ_WANT4,
        SEQ_READY
    } seq_t;

    typedef enum logic [2:0] {
        CK_NONE,
        CK_RESTART,
        CK_EOI_LOW,
        CK_EOI_LVL,
        CK_SELECT,
        CK_BAD
    } cmd_kind_t;

    function automatic byte_t lowest_only(input byte_t v);
        return v & (~v + byte_t'(1));
    endfunction

    function automatic seq_t after_word2(input byte_t w1);
        if (!w1[SOLO_BIT])      return SEQ_WANT3;
        else if (w1[WANT4_BIT]) return SEQ_WANT4;
        else                    return SEQ_READY;
    endfunction

    function automatic seq_t after_word3(input byte_t w1);
        return w1[WANT4_BIT] ? SEQ_WANT4 : SEQ_READY;
    endfunction

endpackage

// File: rtl/picc_cmd_classify.sv
module picc_cmd_classify
    import picc_pkg::*;
(
    input  logic      wr,
    input  byte_t     data,
    input  logic      is_ready,
    output cmd_kind_t kind
);

    always_comb begin
        kind = CK_NONE;
        if (wr) begin
            if (data[RESTART_BIT]) begin
                kind = CK_RESTART;
            end else if (!is_ready) begin
                kind = CK_BAD;
            end else if (data[KIND_BIT]) begin
                kind = CK_SELECT;
            end else begin
                // bits 7:5 : rotate, specific, end-of-interrupt
                case (data[7:5])
                    3'b001:  kind = CK_EOI_LOW;
                    3'b011:  kind = CK_EOI_LVL;
                    default: kind = CK_BAD;
                endcase
            end
        end
    end

endmodule

// File: rtl/picc_eoi_unit.sv
module picc_eoi_unit
    import picc_pkg::*;
(
    input  cmd_kind_t kind,
    input  lvl_t      level,
    input  byte_t     svc,
    output byte_t     clr
);

    always_comb begin
        case (kind)
            CK_EOI_LOW: clr = lowest_only(svc);
            CK_EOI_LVL: clr = byte_t'(1) << level;
            default:    clr = '0;
        endcase
    end

endmodule

// File: rtl/picc_init_seq.sv
module picc_init_seq
    import picc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  restart,
    input  byte_t restart_byte,
    input  logic  dat_stb,
    input  byte_t dat_byte,
    output seq_t  state,
    output byte_t word1,
    output byte_t word2,
    output byte_t word3,
    output byte_t word4,
    output byte_t mask,
    output logic  dat_err
);

    always_comb begin
        dat_err = 1'b0;
        if (dat_stb && !restart) begin
            case (state)
                SEQ_WANT2, SEQ_WANT3, SEQ_WANT4, SEQ_READY: dat_err = 1'b0;
                default:                                    dat_err = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            word1 <= '0;
            word2 <= '0;
            word3 <= '0;
            word4 <= '0;
            mask  <= '1;
        end else if (restart) begin
            word1 <= restart_byte;
            state <= SEQ_WANT2;
        end else if (dat_stb) begin
            case (state)
                SEQ_WANT2: begin
                    word2 <= dat_byte;
                    state <= after_word2(word1);
                end
                SEQ_WANT3: begin
                    word3 <= dat_byte;
                    state <= after_word3(word1);
                end
                SEQ_WANT4: begin
                    word4 <= dat_byte;
                    state <= SEQ_READY;
                end
                SEQ_READY: mask <= dat_byte;
                default: ;
            endcase
        end
    end

    // R2: a restart byte always leads to expecting word 2
    a_r2_restart_to_word2: assert property (@(posedge clk) disable iff (rst)
        restart |=> state == SEQ_WANT2);

    // R10: data write while idle keeps the sequencer and mask
    a_r10_idle_data_ignored: assert property (@(posedge clk) disable iff (rst)
        (dat_stb && !restart && state == SEQ_IDLE) |=> (state == SEQ_IDLE && $stable(mask)));

    // R4: the mask moves only after a data write in the ready state
    a_r4_mask_source: assert property (@(posedge clk) disable iff (rst)
        !$stable(mask) |-> ($past(state) == SEQ_READY && $past(dat_stb) && !$past(restart)));

endmodule

// File: rtl/picc_cmd_if.sv
module picc_cmd_if
    import picc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_wr,
    input  logic                 cmd_rd,
    input  logic [BYTE_W-1:0]    cmd_wdata,
    output logic [BYTE_W-1:0]    cmd_rdata,
    input  logic                 dat_wr,
    input  logic                 dat_rd,
    input  logic [BYTE_W-1:0]    dat_wdata,
    output logic [BYTE_W-1:0]    dat_rdata,
    input  logic [BYTE_W-1:0]    req_in,
    input  logic [BYTE_W-1:0]    svc_in,
    output logic [BYTE_W-1:0]    svc_clr,
    output logic                 err,
    output logic                 ready,
    output logic [BYTE_W-1:0]    init_word1,
    output logic [BYTE_W-1:0]    init_word2,
    output logic [BYTE_W-1:0]    init_word3,
    output logic [BYTE_W-1:0]    init_word4,
    output logic [BYTE_W-1:0]    irq_mask,
    output logic [BYTE_W-1:0]    last_eoi_cmd,
    output logic [BYTE_W-1:0]    read_sel_cmd
);

    cmd_kind_t kind;
    seq_t      state;
    byte_t     clr_next;
    logic      dat_err;
    logic      dat_stb;

    assign ready   = (state == SEQ_READY);
    assign dat_stb = dat_wr && !cmd_wr;

    picc_cmd_classify u_classify (
        .wr       (cmd_wr),
        .data     (cmd_wdata),
        .is_ready (ready),
        .kind     (kind)
    );

    picc_init_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .restart      (kind == CK_RESTART),
        .restart_byte (cmd_wdata),
        .dat_stb      (dat_stb),
        .dat_byte     (dat_wdata),
        .state        (state),
        .word1        (init_word1),
        .word2        (init_word2),
        .word3        (init_word3),
        .word4        (init_word4),
        .mask         (irq_mask),
        .dat_err      (dat_err)
    );

    picc_eoi_unit u_eoi (
        .kind  (kind),
        .level (cmd_wdata[LVL_W-1:0]),
        .svc   (svc_in),
        .clr   (clr_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            last_eoi_cmd <= '0;
            read_sel_cmd <= '0;
            svc_clr      <= '0;
            err          <= 1'b0;
        end else begin
            svc_clr <= clr_next;
            err     <= (kind == CK_BAD) || dat_err;
            if (kind == CK_EOI_LOW || kind == CK_EOI_LVL) last_eoi_cmd <= cmd_wdata;
            if (kind == CK_SELECT)                        read_sel_cmd <= cmd_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_rdata <= '0;
            dat_rdata <= '0;
        end else begin
            if (cmd_rd) begin
                case (read_sel_cmd[1:0])
                    2'b10:   cmd_rdata <= req_in;
                    2'b11:   cmd_rdata <= svc_in;
                    default: cmd_rdata <= '0;
                endcase
            end
            if (dat_rd) dat_rdata <= irq_mask;
        end
    end

    // R6 / R7: at most one in-service bit cleared per command
    a_r6_clear_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(svc_clr));

    // R6: lowest-bit clear only targets a bit that was in service
    a_r6_low_targets_set_bit: assert property (@(posedge clk) disable iff (rst)
        (kind == CK_EOI_LOW) |=> ((svc_clr & ~$past(svc_in)) == '0));

    // R9: command without restart bit before ready raises the error
    a_r9_early_cmd_flags: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !cmd_wdata[RESTART_BIT] && !ready) |=> err);

    // R11: every error pulse follows a write
    a_r11_err_after_write: assert property (@(posedge clk) disable iff (rst)
        err |-> ($past(cmd_wr) || $past(dat_wr)));

    // R8: a rejected command stores nothing and clears nothing
    a_r8_bad_no_effect: assert property (@(posedge clk) disable iff (rst)
        (kind == CK_BAD) |=> ($stable(last_eoi_cmd) && $stable(read_sel_cmd) && svc_clr == '0));

endmodule

// File: tb/picc_cmd_if_tb.sv
`timescale 1ns/100ps
module picc_cmd_if_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       cmd_wr, cmd_rd, dat_wr, dat_rd;
    logic [7:0] cmd_wdata, dat_wdata, req_in, svc_in;
    logic [7:0] cmd_rdata, dat_rdata, svc_clr;
    logic       err, ready;
    logic [7:0] init_word1, init_word2, init_word3, init_word4;
    logic [7:0] irq_mask, last_eoi_cmd, read_sel_cmd;

    int vectors = 0;
    int miscompares = 0;

    always #2.5 clk = ~clk;

    picc_cmd_if u_dut (
        .clk(clk), .rst(rst),
        .cmd_wr(cmd_wr), .cmd_rd(cmd_rd), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
        .dat_wr(dat_wr), .dat_rd(dat_rd), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
        .req_in(req_in), .svc_in(svc_in), .svc_clr(svc_clr), .err(err), .ready(ready),
        .init_word1(init_word1), .init_word2(init_word2), .init_word3(init_word3),
        .init_word4(init_word4), .irq_mask(irq_mask), .last_eoi_cmd(last_eoi_cmd),
        .read_sel_cmd(read_sel_cmd)
    );

    // op codes
    localparam logic [3:0] CW = 4'd0, DW = 4'd1, CR = 4'd2, DR = 4'd3, NP = 4'd4;
    // observed-output selectors
    localparam logic [3:0] S_ERR = 4'd0, S_CLR = 4'd1, S_CRD = 4'd2, S_DRD = 4'd3,
                           S_MSK = 4'd4, S_RDY = 4'd5, S_W1 = 4'd6, S_W2 = 4'd7,
                           S_W3 = 4'd8, S_W4 = 4'd9, S_EOI = 4'd10, S_SEL = 4'd11;

    // {req, op, data, req_in, svc_in, sel, expected}
    localparam int NV = 35;
    localparam logic [43:0] VEC [NV] = '{
        {4'd2,  CW, 8'h11, 8'h00, 8'h00, S_W1,  8'h11}, // R2 restart, two-chip, want word 4
        {4'd3,  DW, 8'h20, 8'h00, 8'h00, S_W2,  8'h20}, // R3
        {4'd3,  DW, 8'h04, 8'h00, 8'h00, S_W3,  8'h04}, // R3
        {4'd3,  DW, 8'h01, 8'h00, 8'h00, S_W4,  8'h01}, // R3
        {4'd3,  NP, 8'h00, 8'h00, 8'h00, S_RDY, 8'h01}, // R3 ready after word 4
        {4'd4,  DW, 8'hA5, 8'h00, 8'h00, S_MSK, 8'hA5}, // R4
        {4'd4,  DR, 8'h00, 8'h00, 8'h00, S_DRD, 8'hA5}, // R4
        {4'd5,  CW, 8'h0A, 8'h00, 8'h00, S_SEL, 8'h0A}, // R5 select request vector
        {4'd5,  CR, 8'h00, 8'h3C, 8'h00, S_CRD, 8'h3C}, // R5
        {4'd5,  CW, 8'h0B, 8'h00, 8'h00, S_SEL, 8'h0B}, // R5 select in-service
        {4'd5,  CR, 8'h00, 8'h3C, 8'h50, S_CRD, 8'h50}, // R5
        {4'd5,  CW, 8'h09, 8'h00, 8'h00, S_SEL, 8'h09}, // R5 select nothing
        {4'd5,  CR, 8'h00, 8'hFF, 8'hFF, S_CRD, 8'h00}, // R5
        {4'd6,  CW, 8'h20, 8'h00, 8'h28, S_CLR, 8'h08}, // R6 lowest of 0x28
        {4'd6,  CW, 8'h20, 8'h00, 8'h00, S_CLR, 8'h00}, // R6 empty in-service
        {4'd6,  NP, 8'h00, 8'h00, 8'h00, S_EOI, 8'h20}, // R6 stored
        {4'd7,  CW, 8'h63, 8'h00, 8'h00, S_CLR, 8'h08}, // R7 level 3
        {4'd7,  CW, 8'h67, 8'h00, 8'h00, S_CLR, 8'h80}, // R7 level 7
        {4'd8,  CW, 8'hE0, 8'h00, 8'hFF, S_ERR, 8'h01}, // R8 rotate form
        {4'd8,  NP, 8'h00, 8'h00, 8'h00, S_EOI, 8'h67}, // R8 not stored, R11 err low
        {4'd8,  CW, 8'h40, 8'h00, 8'hFF, S_ERR, 8'h01}, // R8 specific w/o eoi
        {4'd2,  CW, 8'h13, 8'h00, 8'h00, S_RDY, 8'h00}, // R2 restart while ready
        {4'd3,  DW, 8'h30, 8'h00, 8'h00, S_W2,  8'h30}, // R3
        {4'd3,  DW, 8'h02, 8'h00, 8'h00, S_W4,  8'h02}, // R3 word 3 skipped
        {4'd3,  NP, 8'h00, 8'h00, 8'h00, S_W3,  8'h04}, // R3 word 3 kept
        {4'd3,  NP, 8'h00, 8'h00, 8'h00, S_RDY, 8'h01}, // R3
        {4'd2,  CW, 8'h10, 8'h00, 8'h00, S_W1,  8'h10}, // R2
        {4'd3,  DW, 8'h40, 8'h00, 8'h00, S_W2,  8'h40}, // R3
        {4'd3,  DW, 8'h08, 8'h00, 8'h00, S_W3,  8'h08}, // R3
        {4'd3,  NP, 8'h00, 8'h00, 8'h00, S_RDY, 8'h01}, // R3 word 4 skipped
        {4'd3,  NP, 8'h00, 8'h00, 8'h00, S_W4,  8'h02}, // R3 word 4 kept
        {4'd2,  CW, 8'h12, 8'h00, 8'h00, S_W1,  8'h12}, // R2
        {4'd3,  DW, 8'h50, 8'h00, 8'h00, S_RDY, 8'h01}, // R3 ready after word 2 only
        {4'd4,  DW, 8'h77, 8'h00, 8'h00, S_MSK, 8'h77}, // R4
        {4'd3,  NP, 8'h00, 8'h00, 8'h00, S_W2,  8'h50}  // R3
    };

    function automatic logic [7:0] observe(input logic [3:0] sel);
        case (sel)
            S_ERR:   return {7'd0, err};
            S_CLR:   return svc_clr;
            S_CRD:   return cmd_rdata;
            S_DRD:   return dat_rdata;
            S_MSK:   return irq_mask;
            S_RDY:   return {7'd0, ready};
            S_W1:    return init_word1;
            S_W2:    return init_word2;
            S_W3:    return init_word3;
            S_W4:    return init_word4;
            S_EOI:   return last_eoi_cmd;
            default: return read_sel_cmd;
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // drive one operation for one clock; outputs are valid on return
    task automatic apply(input logic [3:0] op, input logic [7:0] data,
                         input logic [7:0] req, input logic [7:0] svc);
        @(negedge clk);
        cmd_wr = (op == CW);
        dat_wr = (op == DW);
        cmd_rd = (op == CR);
        dat_rd = (op == DR);
        cmd_wdata = data;
        dat_wdata = data;
        req_in = req;
        svc_in = svc;
        @(negedge clk);
        cmd_wr = 1'b0; dat_wr = 1'b0; cmd_rd = 1'b0; dat_rd = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        #50000;
        miscompares++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1;
        cmd_wr = 0; cmd_rd = 0; dat_wr = 0; dat_rd = 0;
        cmd_wdata = 0; dat_wdata = 0; req_in = 0; svc_in = 0;
        do_reset();

        // R1 reset state
        check("R1 ready", {7'd0, ready}, 8'h00);
        check("R1 irq_mask", irq_mask, 8'hFF);
        check("R1 read_sel_cmd", read_sel_cmd, 8'h00);
        check("R1 last_eoi_cmd", last_eoi_cmd, 8'h00);
        check("R1 init words", init_word1 | init_word2 | init_word3 | init_word4, 8'h00);
        check("R1 err", {7'd0, err}, 8'h00);
        check("R1 svc_clr", svc_clr, 8'h00);

        // R9 end-of-interrupt byte before initialisation
        apply(CW, 8'h20, 8'h00, 8'hFF);
        check("R9 err", {7'd0, err}, 8'h01);
        check("R9 svc_clr", svc_clr, 8'h00);
        check("R9 last_eoi_cmd", last_eoi_cmd, 8'h00);
        apply(NP, 8'h00, 8'h00, 8'h00);
        check("R11 err drops", {7'd0, err}, 8'h00);

        // R10 data write before initialisation
        apply(DW, 8'h12, 8'h00, 8'h00);
        check("R10 err", {7'd0, err}, 8'h01);
        check("R10 irq_mask", irq_mask, 8'hFF);
        check("R10 ready", {7'd0, ready}, 8'h00);
        check("R10 init_word2", init_word2, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [43:0] v;
            logic [7:0]  obs;
            v = VEC[i];
            apply(v[39:36], v[35:28], v[27:20], v[19:12]);
            obs = observe(v[11:8]);
            vectors++;
            if (obs !== v[7:0] || (v[11:8] != S_ERR && err !== 1'b0)) begin
                miscompares++;
                $display("FAIL vector %0d R%0d actual=%02h expected=%02h err=%0b",
                         i, v[43:40], obs, v[7:0], err);
            end
        end

        // R12 simultaneous command and data write: data dropped
        @(negedge clk);
        cmd_wr = 1'b1; dat_wr = 1'b1;
        cmd_wdata = 8'h0B; dat_wdata = 8'h33;
        @(negedge clk);
        cmd_wr = 1'b0; dat_wr = 1'b0;
        check("R12 irq_mask", irq_mask, 8'h77);
        check("R12 read_sel_cmd", read_sel_cmd, 8'h0B);
        check("R12 err", {7'd0, err}, 8'h00);

        // R11 back-to-back bad writes then quiet
        apply(CW, 8'hC0, 8'h00, 8'h00);
        check("R11 first err", {7'd0, err}, 8'h01);
        apply(CW, 8'h00, 8'h00, 8'h00);
        check("R11 second err", {7'd0, err}, 8'h01);
        apply(NP, 8'h00, 8'h00, 8'h00);
        check("R11 err quiet", {7'd0, err}, 8'h00);

        // R1 reset again from a used state
        do_reset();
        check("R1 re-reset mask", irq_mask, 8'hFF);
        check("R1 re-reset ready", {7'd0, ready}, 8'h00);

        summary();
        $finish;
    end

endmodule